// File: doc/BRIEF.md
# Runt-Free Per-Output Clock Freeze Gate

This block sits between a group of free-running internal clocks and the output pins they drive. Each freezable output has a run bit that can be changed at any time from an unrelated domain. Clearing the bit parks the output at logic 0. Setting it lets the output follow its clock again. Both changes take effect only at the output's own natural transitions, so no high phase is ever cut short or started late.

Each run bit is retimed into its own output's clock domain by a two-stage synchronizer clocked on the falling edge. The last stage of that synchronizer is the gating flag. The output is the internal clock ANDed with this flag. Because the flag only moves while the clock is going low, the AND can only suppress or restore whole high phases.

A separate set of outputs cannot be frozen. Those outputs follow their clocks directly, with no gating in the path. The reset is synchronous and active low. It is applied on each lane's own falling edge and leaves every lane running.

Top module: `clk_freeze_gate`

## Requirements
- R1: A freezable output whose run bit has been 0 for the whole synchronizer latency stays at logic 0, through both phases of its clock.
- R2: A freezable output never produces a shortened high pulse. Every high pulse lasts exactly one high phase of its own internal clock.
- R3: A freezable output goes from 0 to 1 only at the moment its internal clock rises, including the first pulse after an unfreeze.
- R4: The level of a lane's run bit sampled at falling edge N decides whether the high phase that ends at falling edge N+2 appears on the output (1 = pass, 0 = suppress).
- R5: Non-freezable outputs equal their internal clocks at all times, whatever the run bits.
- R6: While reset is low, each lane's synchronizer and gating flag are set to run on its falling edges. The two high phases after reset release therefore pass regardless of the run bit.
- R7: Lanes are independent. A run bit only affects the output with the same index.
- R8: A freezable output is never high while its internal clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled on each lane's falling edge |
| frz_clk_in | input | N_FRZ | Free-running internal clocks of the freezable lanes |
| frz_run_async | input | N_FRZ | Per-lane run bits (1 = run, 0 = freeze), asynchronous to every lane |
| frz_clk_out | output | N_FRZ | Gated output clocks of the freezable lanes |
| pass_clk_in | input | N_PASS | Internal clocks of the non-freezable lanes |
| pass_clk_out | output | N_PASS | Ungated outputs of the non-freezable lanes |

## Verification
The assertions check several properties on every falling edge of every lane. They check the exact two-edge relation between a sampled run bit and the high phase that appears (R4, which also covers R1 and R3). They check that the output is quiet during the clock's low phase, that the lane runs just after reset, and that the pass-through lanes copy their clocks.

Some behaviours only the bench's scenarios can show. Three unrelated clock periods run at once, and run bits toggle faster than the slowest clock. The bench measures the exact width and rise instant of every output pulse. Reset is reasserted while lanes are frozen. Lane independence shows up because only one bit is toggled while its neighbours are compared.

// File: rtl/clk_freeze_pkg.sv
`timescale 1ns/100ps
// Shared definitions for the clock freeze gate.
// Assumes: nothing beyond IEEE 1800-2017.
package clk_freeze_pkg;
    // Minimum synchronizer depth the lanes accept.
    localparam int unsigned MIN_SYNC_STAGES = 2;

    // State of a lane's gating flag.
    typedef enum logic {
        GATE_STOP = 1'b0,
        GATE_RUN  = 1'b1
    } gate_e;
endpackage

// File: rtl/freeze_sync.sv
`timescale 1ns/100ps
// Falling-edge multi-stage synchronizer for a single control bit.
// Assumes: STAGES >= 2; rst_n is synchronous and active low;
// all stages preset to RST_VAL while reset is held.
module freeze_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous bit through the chain on every falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    // The oldest stage is the synchronized value.
    assign q = chain[STAGES-1];
endmodule

// File: rtl/freeze_lane.sv
`timescale 1ns/100ps
// One freezable output lane: retimes the run bit into the lane's own
// clock domain and ANDs the clock with the resulting gating flag.
// Assumes: the flag only changes on falling edges, so the AND can only
// remove or restore whole high phases; frozen level is logic 0.
module freeze_lane
    import clk_freeze_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic run_async,
    output logic clk_out
);
    logic  run_sync;
    gate_e gate;

    // Retime the run request; the last stage doubles as the gating flag.
    freeze_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk_in),
        .rst_n(rst_n),
        .d    (run_async),
        .q    (run_sync)
    );

    // Interpret the synchronized bit as the gate state.
    assign gate = gate_e'(run_sync);

    // Gate the clock; only whole high phases pass.
    assign clk_out = clk_in & (gate == GATE_RUN);
endmodule

// File: rtl/clk_freeze_gate.sv
`timescale 1ns/100ps
// Per-output clock freeze gate. N_FRZ lanes can be frozen at logic 0
// without runt pulses; N_PASS lanes follow their clocks unconditionally.
// Assumes: each frz_clk_in bit is free running; frz_run_async may change
// at any time; rst_n is held low for at least two falling edges of the
// slowest lane clock.
module clk_freeze_gate
    import clk_freeze_pkg::*;
#(
    parameter int unsigned N_FRZ       = 10,
    parameter int unsigned N_PASS      = 2,
    parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic              rst_n,
    input  logic [N_FRZ-1:0]  frz_clk_in,
    input  logic [N_FRZ-1:0]  frz_run_async,
    output logic [N_FRZ-1:0]  frz_clk_out,
    input  logic [N_PASS-1:0] pass_clk_in,
    output logic [N_PASS-1:0] pass_clk_out
);
    // One gated lane per freezable output.
    for (genvar i = 0; i < N_FRZ; i++) begin : g_frz
        freeze_lane #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_lane (
            .clk_in   (frz_clk_in[i]),
            .rst_n    (rst_n),
            .run_async(frz_run_async[i]),
            .clk_out  (frz_clk_out[i])
        );
    end

    // Non-freezable outputs are straight wires.
    for (genvar j = 0; j < N_PASS; j++) begin : g_pass
        assign pass_clk_out[j] = pass_clk_in[j];
    end
endmodule

// File: rtl/clk_freeze_gate_chk.sv
`timescale 1ns/100ps
// Property checker for clk_freeze_gate, attached with bind.
// Assumes the default two-stage synchronizer latency.
module clk_freeze_gate_chk #(
    parameter int unsigned N_FRZ  = 10,
    parameter int unsigned N_PASS = 2
) (
    input logic              rst_n,
    input logic [N_FRZ-1:0]  frz_clk_in,
    input logic [N_FRZ-1:0]  frz_run_async,
    input logic [N_FRZ-1:0]  frz_clk_out,
    input logic [N_PASS-1:0] pass_clk_in,
    input logic [N_PASS-1:0] pass_clk_out
);
    for (genvar i = 0; i < N_FRZ; i++) begin : g_lane
        // R8
        low_phase_quiet_chk: assert property (
            @(posedge frz_clk_in[i]) disable iff (!rst_n)
            !frz_clk_out[i]);

        // R4
        run_latency_chk: assert property (
            @(negedge frz_clk_in[i]) disable iff (!rst_n)
            ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3))
            |-> (frz_clk_out[i] == $past(frz_run_async[i], 2)));

        // R6
        reset_run_chk: assert property (
            @(negedge frz_clk_in[i]) disable iff (!rst_n)
            (!$past(rst_n, 1) || !$past(rst_n, 2)) |-> frz_clk_out[i]);
    end

    for (genvar j = 0; j < N_PASS; j++) begin : g_pass
        // R5
        pass_high_chk: assert property (
            @(negedge pass_clk_in[j]) disable iff (!rst_n)
            pass_clk_out[j]);

        // R5
        pass_low_chk: assert property (
            @(posedge pass_clk_in[j]) disable iff (!rst_n)
            !pass_clk_out[j]);
    end
endmodule

bind clk_freeze_gate clk_freeze_gate_chk #(
    .N_FRZ (N_FRZ),
    .N_PASS(N_PASS)
) u_chk (
    .rst_n        (rst_n),
    .frz_clk_in   (frz_clk_in),
    .frz_run_async(frz_run_async),
    .frz_clk_out  (frz_clk_out),
    .pass_clk_in  (pass_clk_in),
    .pass_clk_out (pass_clk_out)
);

// File: tb/clk_freeze_gate_bench.sv
`timescale 1ns/100ps
module clk_freeze_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PER_B      = 14;
    localparam int PER_C      = 22;
    localparam int N_FRZ      = 10;
    localparam int N_PASS     = 2;

    function automatic int per_of(input int g);
        return (g == 0) ? CLK_PERIOD : ((g == 1) ? PER_B : PER_C);
    endfunction

    logic [2:0]        gclk = 3'b000;
    logic              rst_n;
    logic              active;
    logic [N_FRZ-1:0]  run_en;
    logic [N_FRZ-1:0]  fin, fout;
    logic [N_PASS-1:0] pin, pout;
    int                n_chk = 0;
    int                n_err = 0;
    event              sample_ev, r6_ev;

    always #(CLK_PERIOD/2) gclk[0] = ~gclk[0];
    always #(PER_B/2)      gclk[1] = ~gclk[1];
    always #(PER_C/2)      gclk[2] = ~gclk[2];

    always_comb begin
        for (int i = 0; i < N_FRZ; i++)  fin[i] = gclk[i % 3];
        for (int j = 0; j < N_PASS; j++) pin[j] = gclk[(j + 1) % 3];
    end

    clk_freeze_gate #(.N_FRZ(N_FRZ), .N_PASS(N_PASS)) u_clk_freeze_gate (
        .rst_n(rst_n), .frz_clk_in(fin), .frz_run_async(run_en),
        .frz_clk_out(fout), .pass_clk_in(pin), .pass_clk_out(pout));

    task automatic check(input bit ok, input string tag, input int lane,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s lane %0d at %0t: actual=%0d expected=%0d",
                     tag, lane, $time, act, exp);
        end
    endtask

    for (genvar g = 0; g < N_FRZ; g++) begin : g_model
        localparam int P = per_of(g % 3);
        logic flag_m;
        bit   pend[$];
        int   negs_since_rst;
        int   rise_cnt;
        real  t_rise;
        bit   got_rise;

        // Reference: value sampled at one falling edge becomes the flag at the next.
        always @(negedge fin[g]) begin
            if (!rst_n) begin
                flag_m = 1'b1;
                pend = '{1'b1};
                negs_since_rst = 0;
            end else begin
                flag_m = pend.pop_front();
                pend.push_back(run_en[g]);
                negs_since_rst++;
            end
        end

        // Compare against the model at every sample point (R1, R4, R6, R7, R8).
        always @(sample_ev) begin
            if (negs_since_rst < 2)
                check(fout[g] === (fin[g] & flag_m), "R6", g, int'(fout[g]), int'(fin[g] & flag_m));
            else if (!flag_m)
                check(fout[g] === 1'b0, "R1", g, int'(fout[g]), 0);
            else
                check(fout[g] === fin[g], "R4 R7", g, int'(fout[g]), int'(fin[g]));
        end

        // Rise instants must coincide with the lane clock's rise (R3).
        always @(posedge fout[g]) begin
            if (active) begin
                t_rise = $realtime;
                got_rise = 1'b1;
                rise_cnt++;
                check(((int'($realtime) - P/2) % P) == 0, "R3", g,
                      int'($realtime), P/2);
            end
        end

        // Every high pulse is one full high phase (R2).
        always @(negedge fout[g]) begin
            if (active && got_rise)
                check(int'($realtime - t_rise) == P/2, "R2", g,
                      int'($realtime - t_rise), P/2);
        end

        // Lanes are running shortly after reset release (R6).
        always @(r6_ev) check(rise_cnt >= 1, "R6", g, rise_cnt, 1);

        always @(negedge active) begin
            got_rise = 1'b0;
            rise_cnt = 0;
        end
    end

    // Pass-through lanes always equal their clocks (R5).
    always @(sample_ev) begin
        for (int j = 0; j < N_PASS; j++)
            check(pout[j] === pin[j], "R5", N_FRZ + j, int'(pout[j]), int'(pin[j]));
    end

    initial begin
        #2.5;
        forever begin
            #(CLK_PERIOD);
            if (active) -> sample_ev;
        end
    end

    initial begin
        logic [N_FRZ-1:0] lfsr;
        rst_n = 1'b0; active = 1'b0; run_en = '1;
        #150.3;
        rst_n = 1'b1; active = 1'b1;
        #60 -> r6_ev;
        #200 run_en = '0;
        #300 run_en = 10'b1010101010;
        #300;
        for (int k = 0; k < 60; k++) begin
            run_en[3] = ~run_en[3];
            #(3 + k % 9);
        end
        lfsr = 10'h2D5;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
            run_en = lfsr;
            #17;
        end
        run_en = '0;
        #100 active = 1'b0; rst_n = 1'b0;
        #100 rst_n = 1'b1; active = 1'b1;
        #60 -> r6_ev;
        #200;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule